// File: doc/BRIEF.md
# Strip-Mining Vector Length Sequencer

This block turns a loop of any trip count into a series of strips that each fit the maximum hardware vector length. A single start pulse loads a signed trip count. The block then offers one strip at a time to a downstream vector unit. Each strip carries an element count and the index of its first element. After the unit accepts a strip, the sequencer waits for a strip-done pulse from it. It then moves on to the next strip, or reports that the loop is complete.

The odd part of the trip count is issued first. The first strip covers the trip count modulo the maximum vector length, or a full strip when that remainder is zero. Every strip after it is full length, so the base index of each later strip equals the first strip length plus a whole number of full strips. A trip count of zero or below produces no strip and only the completion pulse.

Top module: `vl_strip_seq`

## Requirements
- R1: While reset is held and after it is released, stripValid, loopDone and busy are all 0 until a start is accepted.
- R2: A start whose trip count is zero or negative (bit 23 set, two's complement) issues no strip. loopDone goes high in the cycle after the start edge and stays high for exactly one cycle.
- R3: For a positive trip count T, the first strip is offered in the cycle after the start edge. It has stripBase 0 and stripLen equal to T mod 64, or 64 when T is a multiple of 64. Any offered stripLen is between 1 and 64.
- R4: Every strip after the first has stripLen 64. Its stripBase equals the previous strip's stripBase plus the previous stripLen.
- R5: While stripValid is high and stripReady is low, stripValid, stripLen and stripBase hold steady. In the cycle after a handshake (stripValid and stripReady both high at an edge), stripValid is 0.
- R6: After a handshake, no new strip is offered until stripDone is seen high at an edge. The next strip is then offered in the following cycle. A stripDone pulse while a strip is still waiting for acceptance has no effect.
- R7: The strip-done of the last strip, where the remaining count equals the strip length, makes loopDone high for exactly one cycle, in the following cycle. A loop issues exactly ceil(T/64) strips.
- R8: A start pulse while busy is high has no effect on the strips in progress and raises no loopDone.
- R9: busy is high from the cycle after an accepted start through the cycle in which loopDone is high, and low in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a loop when idle |
| tripCount | input | 24 | Signed trip count, sampled with start |
| stripValid | output | 1 | A strip is being offered |
| stripReady | input | 1 | Downstream accepts the offered strip |
| stripLen | output | 7 | Element count of the offered strip (1 to 64) |
| stripBase | output | 24 | Index of the first element of the offered strip |
| stripDone | input | 1 | Pulse from downstream: the accepted strip has finished |
| busy | output | 1 | A loop is in progress |
| loopDone | output | 1 | One-cycle pulse: the loop is complete |

## Verification
Every result is due exactly one cycle after the edge that causes it. A start leads to the first strip or to loopDone one cycle later. A handshake leads to stripValid low one cycle later. A strip-done leads to the next strip or to loopDone one cycle later. The bench drives inputs two time units after a rising edge and samples outputs on the falling edge that follows the causing edge. Every offered strip is compared against a queue of lengths and bases worked out from the trip count. The one-cycle width of loopDone is checked on the falling edge after that.

// File: rtl/vl_strip_pkg.sv
package vl_strip_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_FIN
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // capture a new trip count
    logic advance;  // retire the current strip
  } dpStrobe_t;

endpackage

// File: rtl/vl_strip_dp.sv
module vl_strip_dp
  import vl_strip_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int MAX_VL = 64,
  parameter int LEN_W  = $clog2(MAX_VL) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic [CNT_W-1:0] tripCount,
  output logic [LEN_W-1:0] curLen,
  output logic [CNT_W-1:0] baseIdx,
  output logic             lastStrip,
  output logic             tripNonPos
);

  localparam int MOD_W = $clog2(MAX_VL);
  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(MAX_VL);

  logic [CNT_W-1:0] remCnt;
  logic [MOD_W-1:0] modPart;
  logic [LEN_W-1:0] firstLen;
  logic [CNT_W-1:0] lenWide;

  assign modPart    = tripCount[MOD_W-1:0];
  assign firstLen   = (modPart == '0) ? FULL_LEN : {1'b0, modPart};
  assign tripNonPos = tripCount[CNT_W-1] || (tripCount == '0);
  assign lenWide    = CNT_W'(curLen);
  assign lastStrip  = (remCnt == lenWide);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remCnt  <= '0;
      baseIdx <= '0;
      curLen  <= '0;
    end else if (strb.load) begin
      remCnt  <= tripCount;
      baseIdx <= '0;
      curLen  <= firstLen;
    end else if (strb.advance) begin
      remCnt  <= remCnt - lenWide;
      baseIdx <= baseIdx + lenWide;
      curLen  <= FULL_LEN;
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |-> (remCnt >= lenWide)); // R4

  AST_REM_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.advance) |-> (remCnt[MOD_W-1:0] == '0)); // R3

endmodule

// File: rtl/vl_strip_ctrl.sv
module vl_strip_ctrl
  import vl_strip_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      tripNonPos,
  input  logic      lastStrip,
  input  logic      stripReady,
  input  logic      stripDone,
  output dpStrobe_t strb,
  output logic      stripValid,
  output logic      busy,
  output logic      loopDone
);

  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState  = state;
    strb       = '0;
    stripValid = 1'b0;
    loopDone   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          if (tripNonPos) begin
            nextState = ST_FIN;
          end else begin
            strb.load = 1'b1;
            nextState = ST_ISSUE;
          end
        end
      end
      ST_ISSUE: begin
        stripValid = 1'b1;
        if (stripReady) nextState = ST_WAIT;
      end
      ST_WAIT: begin
        if (stripDone) begin
          strb.advance = 1'b1;
          nextState    = lastStrip ? ST_FIN : ST_ISSUE;
        end
      end
      ST_FIN: begin
        loopDone  = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    loopDone |=> !loopDone); // R7

  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !loopDone && start) |=> busy); // R8

  AST_NEXT_STRIP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !lastStrip) |=> stripValid); // R6

endmodule

// File: rtl/vl_strip_seq.sv
module vl_strip_seq
  import vl_strip_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int MAX_VL = 64,
  parameter int LEN_W  = $clog2(MAX_VL) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] tripCount,
  output logic             stripValid,
  input  logic             stripReady,
  output logic [LEN_W-1:0] stripLen,
  output logic [CNT_W-1:0] stripBase,
  input  logic             stripDone,
  output logic             busy,
  output logic             loopDone
);

  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(MAX_VL);

  dpStrobe_t strb;
  logic      lastStrip;
  logic      tripNonPos;

  vl_strip_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .tripNonPos (tripNonPos),
    .lastStrip  (lastStrip),
    .stripReady (stripReady),
    .stripDone  (stripDone),
    .strb       (strb),
    .stripValid (stripValid),
    .busy       (busy),
    .loopDone   (loopDone)
  );

  vl_strip_dp #(
    .CNT_W  (CNT_W),
    .MAX_VL (MAX_VL),
    .LEN_W  (LEN_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .tripCount  (tripCount),
    .curLen     (stripLen),
    .baseIdx    (stripBase),
    .lastStrip  (lastStrip),
    .tripNonPos (tripNonPos)
  );

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    stripValid |-> (stripLen != '0 && stripLen <= FULL_LEN)); // R3

  AST_LATER_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (stripValid && stripBase != '0) |-> (stripLen == FULL_LEN)); // R4

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (stripValid && !stripReady) |=> (stripValid && $stable(stripLen) && $stable(stripBase))); // R5

  AST_DROP_AFTER_XFER: assert property (@(posedge clk) disable iff (!rstN)
    (stripValid && stripReady) |=> !stripValid); // R5

endmodule

// File: tb/tb_vl_strip_seq.sv
module tb_vl_strip_seq;
  localparam int CNT_W  = 24;
  localparam int MAX_VL = 64;
  localparam int LEN_W  = 7;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [CNT_W-1:0] tripCount = '0;
  logic             stripValid;
  logic             stripReady = 1'b0;
  logic [LEN_W-1:0] stripLen;
  logic [CNT_W-1:0] stripBase;
  logic             stripDone = 1'b0;
  logic             busy;
  logic             loopDone;

  int nChecks = 0;
  int nFails = 0;
  int seenStrips = 0;
  int doneSeen = 0;
  int expLenQ[$];
  int expBaseQ[$];

  always #5 clk = ~clk;

  vl_strip_seq dut (
    .clk(clk), .rstN(rstN), .start(start), .tripCount(tripCount),
    .stripValid(stripValid), .stripReady(stripReady), .stripLen(stripLen),
    .stripBase(stripBase), .stripDone(stripDone), .busy(busy), .loopDone(loopDone)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // Monitor: pops an expected strip on every handshake
  always @(negedge clk) begin
    int eL;
    int eB;
    if (rstN && stripValid && stripReady) begin
      seenStrips++;
      if (expLenQ.size() == 0) begin
        chk(1'b0, "R7", "strip beyond expected count", stripBase, -1);
      end else begin
        eL = expLenQ.pop_front();
        eB = expBaseQ.pop_front();
        chk(stripLen == LEN_W'(eL), (eB == 0) ? "R3" : "R4", "strip length", stripLen, eL);
        chk(stripBase == CNT_W'(eB), (eB == 0) ? "R3" : "R4", "strip base", stripBase, eB);
      end
    end
    if (rstN && loopDone) doneSeen++;
  end

  // Driver: pushes expectations and plays the downstream unit
  task automatic runLoop(input int tc, input int rdyDly, input int doneDly, input bit poke);
    int rem;
    int base;
    int first;
    int nExp;
    int d0;
    int s0;
    logic [LEN_W-1:0] l0;
    logic [CNT_W-1:0] b0;
    nExp = 0;
    if (tc > 0) begin
      first = (tc % MAX_VL == 0) ? MAX_VL : tc % MAX_VL;
      expLenQ.push_back(first);
      expBaseQ.push_back(0);
      nExp = 1;
      base = first;
      rem = tc - first;
      while (rem > 0) begin
        expLenQ.push_back(MAX_VL);
        expBaseQ.push_back(base);
        base += MAX_VL;
        rem -= MAX_VL;
        nExp++;
      end
    end
    d0 = doneSeen;
    s0 = seenStrips;
    tripCount = CNT_W'(tc);
    start = 1'b1;
    tick();
    start = 1'b0;
    tripCount = '0;
    @(negedge clk);
    if (nExp == 0) begin
      chk(loopDone == 1'b1, "R2", "done after non-positive start", loopDone, 1);
      chk(stripValid == 1'b0, "R2", "no strip offered", stripValid, 0);
      chk(busy == 1'b1, "R9", "busy in done cycle", busy, 1);
      @(negedge clk);
      chk(loopDone == 1'b0, "R2", "done pulse width", loopDone, 0);
      chk(busy == 1'b0, "R9", "idle after done", busy, 0);
    end else begin
      for (int i = 0; i < nExp; i++) begin
        chk(stripValid == 1'b1, (i == 0) ? "R3" : "R6", "strip offered one cycle later", stripValid, 1);
        chk(busy == 1'b1, "R9", "busy while looping", busy, 1);
        l0 = stripLen;
        b0 = stripBase;
        for (int k = 0; k < rdyDly; k++) begin
          tick();
          stripDone = poke;
          start = poke;
          @(negedge clk);
          chk(stripValid == 1'b1, "R5", "valid held", stripValid, 1);
          chk(stripLen == l0, poke ? "R6" : "R5", "length held", stripLen, l0);
          chk(stripBase == b0, poke ? "R8" : "R5", "base held", stripBase, b0);
        end
        tick();
        stripDone = 1'b0;
        start = 1'b0;
        stripReady = 1'b1;
        @(negedge clk);
        tick();
        stripReady = 1'b0;
        @(negedge clk);
        chk(stripValid == 1'b0, "R5", "valid drops after handshake", stripValid, 0);
        for (int k = 0; k < doneDly; k++) begin
          tick();
          start = poke;
          @(negedge clk);
          chk(stripValid == 1'b0, "R6", "no strip before strip-done", stripValid, 0);
          chk(loopDone == 1'b0, "R8", "no done while waiting", loopDone, 0);
        end
        tick();
        start = 1'b0;
        stripDone = 1'b1;
        @(negedge clk);
        tick();
        stripDone = 1'b0;
        @(negedge clk);
        if (i == nExp - 1) begin
          chk(loopDone == 1'b1, "R7", "done after last strip", loopDone, 1);
          chk(stripValid == 1'b0, "R7", "no strip with done", stripValid, 0);
          @(negedge clk);
          chk(loopDone == 1'b0, "R7", "done pulse width", loopDone, 0);
          chk(busy == 1'b0, "R9", "idle after done", busy, 0);
        end
      end
    end
    chk(seenStrips - s0 == nExp, "R7", "strip count", seenStrips - s0, nExp);
    chk(doneSeen - d0 == 1, "R7", "done pulses", doneSeen - d0, 1);
    chk(expLenQ.size() == 0, "R7", "expected strips left", expLenQ.size(), 0);
    tick();
  endtask

  initial begin
    start = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(stripValid == 1'b0, "R1", "valid in reset", stripValid, 0);
    chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
    tick();
    start = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    chk(loopDone == 1'b0, "R1", "done after reset", loopDone, 0);
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    tick();
    runLoop(0, 0, 0, 1'b0);
    runLoop(-5, 0, 0, 1'b0);
    runLoop(1, 0, 0, 1'b0);
    runLoop(64, 2, 1, 1'b0);
    runLoop(65, 1, 2, 1'b1);
    runLoop(63, 3, 0, 1'b1);
    runLoop(128, 0, 3, 1'b0);
    runLoop(200, 2, 2, 1'b1);
    runLoop(1000, 1, 1, 1'b0);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    nChecks++;
    $display("FAIL R7 watchdog: actual hung expected loop completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule